// File: doc/BRIEF.md
# Sequential Multiply, Divide and Multiply-Accumulate Unit

This block is the arithmetic side unit of a 16-bit controller datapath. The issuing logic presents an operation code and two 32-bit source operands, each built from a pair of 16-bit registers, and pulses `start`. The unit computes an 8x8 unsigned product, a signed or unsigned 16x16 product, a 16-bit or 32-bit unsigned quotient and remainder, or a signed or unsigned multiply-accumulate into a 32-bit accumulator that it keeps internally.

Every operation has a fixed latency, so the issuing logic can plan around it. `busy` marks the unit as occupied and `done` marks the cycle in which the results are first valid. Results stay on their outputs until the next operation completes. Only multiply-accumulate completions change the carry and auxiliary flags. The accumulator can also be loaded or cleared through a small write port, which is locked while a multiply-accumulate is in flight.

Top module: `mdu_core`

## Requirements
- R1: Op code 0 multiplies `src_a[7:0]` by `src_b[7:0]` unsigned. `res_q` receives the 16-bit product zero-extended, `res_r` becomes 0, and the operation takes 1 clock.
- R2: Op code 1 (unsigned) and op code 2 (two's-complement signed) multiply `src_a[15:0]` by `src_b[15:0]`. `res_q` receives the full 32-bit product, `res_r` becomes 0, and the operation takes 2 clocks.
- R3: Op code 3 divides `src_a[15:0]` by `src_b[15:0]` unsigned. The 16-bit quotient goes to `res_q[15:0]` and the remainder to `res_r[15:0]`, with both upper halves zero. The operation takes 9 clocks.
- R4: Op code 4 divides `src_a` by `src_b` as 32-bit unsigned values. The quotient goes to `res_q` and the remainder to `res_r`, and the operation takes 17 clocks.
- R5: A divide by a zero divisor takes the normal latency. It returns an all-ones quotient of the operation's width and a remainder equal to the dividend.
- R6: Op codes 5 (unsigned) and 6 (signed) add the product of `src_a[15:0]` and `src_b[15:0]` to the accumulator `acc_q`. The operation takes 3 clocks and leaves `res_q` and `res_r` unchanged.
- R7: For op code 5, `flag_cy` is the carry out of the 32-bit add and `flag_ac` is 0. For op code 6, `flag_cy` is set on signed overflow and `flag_ac` equals bit 31 of the new accumulator.
- R8: The flags change only when a multiply-accumulate completes. Multiplies, divides, accumulator writes and reserved op code 7 leave them unchanged.
- R9: After an accepted start, `busy` is high for exactly the operation's latency in cycles. `done` pulses for one cycle, in the last of those cycles, and the results are valid then. The results hold until the next completion.
- R10: A `start` while `busy` is high is ignored. The running operation keeps its latency, operands and result.
- R11: When no multiply-accumulate is running or being started, `acc_wr_en` loads `acc_wr_data` into the accumulator at the next edge. Otherwise the write is ignored.
- R12: A synchronous active-high `rst` clears `busy`, `done`, the results, the accumulator and both flags, including when an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted when not busy |
| op | input | 3 | Operation code (0..6, 7 reserved) |
| src_a | input | 32 | First operand / dividend |
| src_b | input | 32 | Second operand / divisor |
| acc_wr_en | input | 1 | Accumulator write enable |
| acc_wr_data | input | 32 | Accumulator write value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_q | output | 32 | Product or quotient |
| res_r | output | 32 | Remainder (0 after multiplies) |
| acc_q | output | 32 | Accumulator value |
| flag_cy | output | 1 | Carry / overflow flag |
| flag_ac | output | 1 | Auxiliary flag |

## Verification
The latency assertion assumes that `op` is valid whenever `start` is sampled high. It also assumes that `rst` is held across at least two edges at power-up, so the hold checks see defined history. The bench drives `op`, the operands and `start` on the falling edge and keeps them steady through the accepting rising edge. It holds reset for several cycles before any check, and it raises `start` during `busy` only on purpose, to test that the request is ignored.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL8U  = 3'd0,
    OP_MUL16U = 3'd1,
    OP_MUL16S = 3'd2,
    OP_DIV16U = 3'd3,
    OP_DIV32U = 3'd4,
    OP_MACU   = 3'd5,
    OP_MACS   = 3'd6,
    OP_RSVD   = 3'd7
  } mdu_op_e;

  function automatic int unsigned op_latency(input mdu_op_e o, input int unsigned dw,
                                             input int unsigned bpc);
    case (o)
      OP_MUL8U:            return 1;
      OP_MUL16U, OP_MUL16S: return 2;
      OP_MACU, OP_MACS:    return 3;
      OP_DIV16U:           return 1 + dw / bpc;
      OP_DIV32U:           return 1 + (2 * dw) / bpc;
      default:             return 1;
    endcase
  endfunction

  function automatic logic is_mac(input mdu_op_e o);
    return (o == OP_MACU) || (o == OP_MACS);
  endfunction

  function automatic logic is_div(input mdu_op_e o);
    return (o == OP_DIV16U) || (o == OP_DIV32U);
  endfunction

  function automatic logic is_signed_mul(input mdu_op_e o);
    return (o == OP_MUL16S) || (o == OP_MACS);
  endfunction

endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  sgn,
  input  logic [DATA_W-1:0]     opa,
  input  logic [DATA_W-1:0]     opb,
  output logic [2*DATA_W-1:0]   prod_c,
  output logic [2*DATA_W-1:0]   prod_q
);
  localparam int WW = 2 * DATA_W;

  logic sx_a, sx_b;
  logic [WW-1:0] xa, xb;

  // sign or zero extension to the product width; the low WW bits of the
  // product of the extended values are the exact signed/unsigned result
  assign sx_a = sgn & opa[DATA_W-1];
  assign sx_b = sgn & opb[DATA_W-1];
  assign xa   = {{(WW-DATA_W){sx_a}}, opa};
  assign xb   = {{(WW-DATA_W){sx_b}}, opb};
  assign prod_c = xa * xb;

  always_ff @(posedge clk) begin
    if (rst)       prod_q <= '0;
    else if (load) prod_q <= prod_c;
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int WW  = 32,
  parameter int BPC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [WW-1:0] dividend,
  input  logic [WW-1:0] divisor,
  output logic [WW-1:0] quo_nxt,
  output logic [WW-1:0] rem_nxt
);
  logic [WW-1:0] rq, rr, dr;
  logic [WW-1:0] rq_s [BPC+1];
  logic [WW-1:0] rr_s [BPC+1];

  assign rq_s[0] = rq;
  assign rr_s[0] = rr;

  // BPC restoring stages chained in one cycle
  for (genvar g = 0; g < BPC; g++) begin : g_stage
    logic [WW:0] trial;
    logic        ge;
    logic [WW:0] diff;
    assign trial = {rr_s[g], rq_s[g][WW-1]};
    assign ge    = trial >= {1'b0, dr};
    assign diff  = trial - {1'b0, dr};
    assign rr_s[g+1] = ge ? diff[WW-1:0] : trial[WW-1:0];
    assign rq_s[g+1] = {rq_s[g][WW-2:0], ge};
  end

  assign quo_nxt = rq_s[BPC];
  assign rem_nxt = rr_s[BPC];

  always_ff @(posedge clk) begin
    if (rst) begin
      rq <= '0;
      rr <= '0;
      dr <= '0;
    end else if (load) begin
      rq <= dividend;
      rr <= '0;
      dr <= divisor;
    end else if (step) begin
      rq <= rq_s[BPC];
      rr <= rr_s[BPC];
    end
  end
endmodule

// File: rtl/mdu_acc.sv
module mdu_acc #(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  input  logic          mac_en,
  input  logic          mac_signed,
  input  logic [WW-1:0] prod,
  output logic [WW-1:0] acc,
  output logic          cy,
  output logic          ac
);
  logic [WW:0]   usum;
  logic [WW-1:0] sum;
  logic          s_ovf;

  assign usum  = {1'b0, acc} + {1'b0, prod};
  assign sum   = usum[WW-1:0];
  assign s_ovf = (acc[WW-1] == prod[WW-1]) && (sum[WW-1] != acc[WW-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cy  <= 1'b0;
      ac  <= 1'b0;
    end else if (mac_en) begin
      acc <= sum;
      cy  <= mac_signed ? s_ovf : usum[WW];
      ac  <= mac_signed ? sum[WW-1] : 1'b0;
    end else if (wr_en) begin
      acc <= wr_data;
    end
  end
endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DIV_BPC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2:0]           op,
  input  logic [2*DATA_W-1:0]  src_a,
  input  logic [2*DATA_W-1:0]  src_b,
  input  logic                 acc_wr_en,
  input  logic [2*DATA_W-1:0]  acc_wr_data,
  output logic                 busy,
  output logic                 done,
  output logic [2*DATA_W-1:0]  res_q,
  output logic [2*DATA_W-1:0]  res_r,
  output logic [2*DATA_W-1:0]  acc_q,
  output logic                 flag_cy,
  output logic                 flag_ac
);
  localparam int WW      = 2 * DATA_W;
  localparam int HW      = DATA_W / 2;
  localparam int LAT_MAX = 1 + WW / DIV_BPC;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  mdu_op_e          op_in, op_r, cur_op;
  logic             accept, last_edge;
  int unsigned      lat_in;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] a_r, b_r;

  assign op_in  = mdu_op_e'(op);
  assign accept = start && !busy;
  assign cur_op = accept ? op_in : op_r;
  assign lat_in = op_latency(op_in, DATA_W, DIV_BPC);
  assign last_edge = (accept && lat_in == 1) || (busy && cnt == CNT_W'(1));

  // sequencer: busy for exactly the latency, done on the last busy cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      op_r <= OP_MUL8U;
      a_r  <= '0;
      b_r  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= (lat_in == 1);
      cnt  <= CNT_W'(lat_in - 1);
      op_r <= op_in;
      a_r  <= src_a[DATA_W-1:0];
      b_r  <= src_b[DATA_W-1:0];
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b0;
      end else begin
        cnt  <= cnt - CNT_W'(1);
        done <= (cnt == CNT_W'(1));
      end
    end
  end

  // multiplier operand selection
  logic [DATA_W-1:0] mul_a, mul_b, raw_a, raw_b;
  logic [WW-1:0]     prod_c, prod_q;
  logic              mac_stage1, mac_en, mac_block, wr_ok;

  assign raw_a = accept ? src_a[DATA_W-1:0] : a_r;
  assign raw_b = accept ? src_b[DATA_W-1:0] : b_r;
  assign mul_a = (cur_op == OP_MUL8U) ? {{(DATA_W-HW){1'b0}}, raw_a[HW-1:0]} : raw_a;
  assign mul_b = (cur_op == OP_MUL8U) ? {{(DATA_W-HW){1'b0}}, raw_b[HW-1:0]} : raw_b;

  assign mac_stage1 = busy && is_mac(op_r) && (cnt == CNT_W'(2));
  assign mac_en     = busy && is_mac(op_r) && (cnt == CNT_W'(1));
  assign mac_block  = (busy && is_mac(op_r)) || (accept && is_mac(op_in));
  assign wr_ok      = acc_wr_en && !mac_block;

  mdu_mul #(.DATA_W(DATA_W)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .load   (mac_stage1),
    .sgn    (is_signed_mul(cur_op)),
    .opa    (mul_a),
    .opb    (mul_b),
    .prod_c (prod_c),
    .prod_q (prod_q)
  );

  // divider: a 16-bit dividend is placed in the upper half so that half the
  // iterations retire exactly its bits
  logic [WW-1:0] div_dvd, div_dvs, quo_nxt, rem_nxt;
  logic          div_step;

  assign div_dvd  = (op_in == OP_DIV16U) ? {src_a[DATA_W-1:0], {DATA_W{1'b0}}} : src_a;
  assign div_dvs  = (op_in == OP_DIV16U) ? {{DATA_W{1'b0}}, src_b[DATA_W-1:0]} : src_b;
  assign div_step = busy && is_div(op_r);

  mdu_div #(.WW(WW), .BPC(DIV_BPC)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (accept && is_div(op_in)),
    .step     (div_step),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .quo_nxt  (quo_nxt),
    .rem_nxt  (rem_nxt)
  );

  mdu_acc #(.WW(WW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_ok),
    .wr_data    (acc_wr_data),
    .mac_en     (mac_en),
    .mac_signed (op_r == OP_MACS),
    .prod       (prod_q),
    .acc        (acc_q),
    .cy         (flag_cy),
    .ac         (flag_ac)
  );

  // result registers, written only on the completing edge
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      res_r <= '0;
    end else if (last_edge) begin
      case (cur_op)
        OP_MUL8U: begin
          res_q <= {{DATA_W{1'b0}}, prod_c[DATA_W-1:0]};
          res_r <= '0;
        end
        OP_MUL16U, OP_MUL16S: begin
          res_q <= prod_c;
          res_r <= '0;
        end
        OP_DIV16U: begin
          res_q <= {{DATA_W{1'b0}}, quo_nxt[DATA_W-1:0]};
          res_r <= {{DATA_W{1'b0}}, rem_nxt[DATA_W-1:0]};
        end
        OP_DIV32U: begin
          res_q <= quo_nxt;
          res_r <= rem_nxt;
        end
        default: begin
          res_q <= res_q;
          res_r <= res_r;
        end
      endcase
    end
  end
endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk
  import mdu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DIV_BPC = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [2:0]          op,
  input logic                busy,
  input logic                done,
  input logic [2*DATA_W-1:0] res_q,
  input logic [2*DATA_W-1:0] res_r,
  input logic                flag_cy,
  input logic                flag_ac
);
  int unsigned chk_cnt;
  mdu_op_e     chk_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_cnt <= 0;
      chk_op  <= OP_MUL8U;
    end else if (start && !busy) begin
      chk_cnt <= 1;
      chk_op  <= mdu_op_e'(op);
    end else if (busy) begin
      chk_cnt <= chk_cnt + 1;
    end
  end

  // R9: completion only inside a busy window
  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: busy window length equals the operation latency
  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (chk_cnt == op_latency(chk_op, DATA_W, DIV_BPC)));

  // R9: results held between completions
  assert_res_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_q) && $stable(res_r)));

  // R8: flags move only on a completion
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({flag_cy, flag_ac}));
endmodule

bind mdu_core mdu_core_chk #(.DATA_W(DATA_W), .DIV_BPC(DIV_BPC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .op      (op),
  .busy    (busy),
  .done    (done),
  .res_q   (res_q),
  .res_r   (res_r),
  .flag_cy (flag_cy),
  .flag_ac (flag_ac)
);

// File: tb/mdu_core_test.sv
module mdu_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        acc_wr_en = 1'b0;
  logic [31:0] acc_wr_data = '0;
  logic        busy, done, flag_cy, flag_ac;
  logic [31:0] res_q, res_r, acc_q;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mdu_core uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_a(src_a), .src_b(src_b),
    .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data), .busy(busy), .done(done),
    .res_q(res_q), .res_r(res_r), .acc_q(acc_q), .flag_cy(flag_cy), .flag_ac(flag_ac)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] acc0;
    logic [31:0] q;
    logic [31:0] r;
    logic [31:0] acc;
    logic        cy;
    logic        ac;
    logic [4:0]  lat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{3'd5, 32'h00000003, 32'h00000004, 32'h00000010, 32'h0, 32'h0, 32'h0000001C, 1'b0, 1'b0, 5'd3},
    '{3'd5, 32'h00000001, 32'h00000001, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h00000000, 1'b1, 1'b0, 5'd3},
    '{3'd6, 32'h0000FFFF, 32'h00000003, 32'h00000000, 32'h0, 32'h0, 32'hFFFFFFFD, 1'b0, 1'b1, 5'd3},
    '{3'd6, 32'h0000FFFF, 32'h00000001, 32'h80000000, 32'h0, 32'h0, 32'h7FFFFFFF, 1'b1, 1'b0, 5'd3},
    '{3'd6, 32'h00000001, 32'h00000001, 32'h7FFFFFFF, 32'h0, 32'h0, 32'h80000000, 1'b1, 1'b1, 5'd3},
    '{3'd0, 32'hABCD12FF, 32'h000034FF, 32'h13572468, 32'h0000FE01, 32'h0, 32'h13572468, 1'b0, 1'b0, 5'd1},
    '{3'd1, 32'h0000FFFF, 32'h0000FFFF, 32'h13572468, 32'hFFFE0001, 32'h0, 32'h13572468, 1'b0, 1'b0, 5'd2},
    '{3'd2, 32'h0000FFFF, 32'h00000002, 32'h13572468, 32'hFFFFFFFE, 32'h0, 32'h13572468, 1'b0, 1'b0, 5'd2},
    '{3'd2, 32'h00008000, 32'h00008000, 32'h13572468, 32'h40000000, 32'h0, 32'h13572468, 1'b0, 1'b0, 5'd2},
    '{3'd2, 32'h00007FFF, 32'h00008000, 32'h13572468, 32'hC0008000, 32'h0, 32'h13572468, 1'b0, 1'b0, 5'd2},
    '{3'd3, 32'hDEAD0064, 32'h00000007, 32'h13572468, 32'h0000000E, 32'h2, 32'h13572468, 1'b0, 1'b0, 5'd9},
    '{3'd3, 32'h00001234, 32'h00000000, 32'h13572468, 32'h0000FFFF, 32'h1234, 32'h13572468, 1'b0, 1'b0, 5'd9},
    '{3'd3, 32'h0000FFFF, 32'h00000001, 32'h13572468, 32'h0000FFFF, 32'h0, 32'h13572468, 1'b0, 1'b0, 5'd9},
    '{3'd4, 32'h12345678, 32'h00010000, 32'h13572468, 32'h00001234, 32'h5678, 32'h13572468, 1'b0, 1'b0, 5'd17},
    '{3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h13572468, 32'h00000001, 32'h0, 32'h13572468, 1'b0, 1'b0, 5'd17},
    '{3'd4, 32'h89ABCDEF, 32'h00000000, 32'h13572468, 32'hFFFFFFFF, 32'h89ABCDEF, 32'h13572468, 1'b0, 1'b0, 5'd17},
    '{3'd4, 32'h00000007, 32'h00000009, 32'h13572468, 32'h00000000, 32'h7, 32'h13572468, 1'b0, 1'b0, 5'd17}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] o, input logic [31:0] b);
    case (o)
      3'd0: return "R1";
      3'd1, 3'd2: return "R2";
      3'd3: return (b[15:0] == 16'h0) ? "R5" : "R3";
      3'd4: return (b == 32'h0) ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic write_acc(input logic [31:0] v);
    @(negedge clk);
    acc_wr_en   = 1'b1;
    acc_wr_data = v;
    @(negedge clk);
    acc_wr_en   = 1'b0;
  endtask

  // runs one op; optionally pokes a start (R10) or an accumulator write (R11)
  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input bit poke_start, input bit poke_wr, output int cyc);
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    if (poke_wr) begin acc_wr_en = 1'b1; acc_wr_data = 32'hAAAA5555; end
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      if (cyc == 1 && poke_start) begin
        start = 1'b1; op = 3'd0; src_a = 32'h2; src_b = 32'h3;
      end
      @(negedge clk);
      start = 1'b0;
      acc_wr_en = 1'b0;
      cyc++;
    end
    acc_wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check(busy == 1'b0 && done == 1'b0, "R12", "busy/done after reset", {30'b0, busy, done}, 32'h0);
    check(res_q == 32'h0 && res_r == 32'h0, "R12", "results after reset", res_q | res_r, 32'h0);
    check(acc_q == 32'h0, "R12", "acc after reset", acc_q, 32'h0);
    check(flag_cy == 1'b0 && flag_ac == 1'b0, "R12", "flags after reset", {30'b0, flag_cy, flag_ac}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pq, pr;
      logic        pcy, pac;
      string       t;
      write_acc(VEC[i].acc0);
      check(acc_q == VEC[i].acc0, "R11", "acc write idle", acc_q, VEC[i].acc0);
      pq = res_q; pr = res_r; pcy = flag_cy; pac = flag_ac;
      t = op_tag(VEC[i].op, VEC[i].b);
      run_op(VEC[i].op, VEC[i].a, VEC[i].b, 1'b0, 1'b0, cyc);
      check(cyc == int'(VEC[i].lat), "R9", "latency", 32'(cyc), 32'(VEC[i].lat));
      check(busy == 1'b1, "R9", "busy with done", {31'b0, busy}, 32'h1);
      if (VEC[i].op >= 3'd5) begin
        check(acc_q == VEC[i].acc, "R6", "mac acc", acc_q, VEC[i].acc);
        check(res_q == pq && res_r == pr, "R6", "mac keeps results", res_q, pq);
        check(flag_cy == VEC[i].cy, "R7", "carry", {31'b0, flag_cy}, {31'b0, VEC[i].cy});
        check(flag_ac == VEC[i].ac, "R7", "aux", {31'b0, flag_ac}, {31'b0, VEC[i].ac});
      end else begin
        check(res_q == VEC[i].q, t, "res_q", res_q, VEC[i].q);
        check(res_r == VEC[i].r, t, "res_r", res_r, VEC[i].r);
        check(acc_q == VEC[i].acc, "R8", "acc untouched", acc_q, VEC[i].acc);
        check(flag_cy == pcy && flag_ac == pac, "R8", "flags unchanged",
              {30'b0, flag_cy, flag_ac}, {30'b0, pcy, pac});
      end
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R9", "idle after done", {30'b0, busy, done}, 32'h0);
      check(res_q == (VEC[i].op >= 3'd5 ? pq : VEC[i].q), "R9", "result held", res_q,
            (VEC[i].op >= 3'd5 ? pq : VEC[i].q));
    end

    // R10: start during busy is ignored
    run_op(3'd4, 32'd100, 32'd3, 1'b1, 1'b0, cyc);
    check(cyc == 17, "R10", "latency with ignored start", 32'(cyc), 32'd17);
    check(res_q == 32'd33 && res_r == 32'd1, "R10", "quotient kept", res_q, 32'd33);
    @(negedge clk);
    check(busy == 1'b0, "R10", "no extra op started", {31'b0, busy}, 32'h0);

    // R11: writes blocked while a MAC starts and runs
    write_acc(32'd5);
    run_op(3'd5, 32'd2, 32'd3, 1'b0, 1'b1, cyc);
    check(acc_q == 32'd11, "R11", "blocked write during mac", acc_q, 32'd11);
    check(cyc == 3, "R6", "mac latency", 32'(cyc), 32'd3);

    // R12: reset during an operation
    @(negedge clk);
    start = 1'b1; op = 3'd4; src_a = 32'hFFFF0000; src_b = 32'h3;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R12", "busy cleared mid-op", {30'b0, busy, done}, 32'h0);
    check(res_q == 32'h0 && acc_q == 32'h0, "R12", "state cleared mid-op", res_q | acc_q, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule